// File: doc/BRIEF.md
# Wide-Vector Warm-Up Throttle

This block sits beside the issue stage of a processor core and models the power state of the wide SIMD datapath. Every cycle the issue logic may present one request together with a two-bit code giving its vector width. Narrow requests go through at once. Wide requests reaching a cold datapath start a warm-up window. During that window wide issue is held to at most one grant every other cycle. Once the window ends, wide issue runs at full rate. A long stretch with no wide issue sends the datapath back to cold.

Only the width code decides whether a request is throttled. The block has no input for operation type, so integer and floating-point operations of the same width are treated the same. A configuration input chooses which widths count as wide: 32 bytes and above, or 64 bytes only. A stalled requester keeps its request asserted until it is granted. The warm-up length (default 56000 cycles) and the idle timeout (default 2.7 million cycles) are parameters.

Top module: `vwarm_throttle`

## Requirements
- R1: A valid request that is not wide gets grant=1 and stall=0 in the same cycle, whatever the state.
- R2: Width codes are 0=16 bytes, 1=32 bytes, 2=64 bytes, 3=reserved and treated as 64 bytes. With wide_cfg=0, codes 1, 2 and 3 are wide. With wide_cfg=1, only codes 2 and 3 are wide.
- R3: The state output is encoded as 0=COLD, 1=WARMING, 2=WARM. A wide request seen in COLD is granted in that cycle, and that cycle counts as the first warm-up cycle.
- R4: While throttled (in COLD, or in WARMING), a wide request is granted only if no wide grant happened in the previous cycle. Otherwise it gets grant=0 and stall=1.
- R5: The warm-up lasts WARM_CYCLES cycles, counted from the COLD cycle that started it. The state reads WARM in the cycle after the last of them.
- R6: In WARM every valid request is granted and stall stays 0.
- R7: In WARM, IDLE_CYCLES consecutive cycles with no wide issue return the state to COLD in the next cycle. Any wide issue restarts this count.
- R8: Synchronous active-high reset puts the block in COLD with both timers cleared and the half-rate history cleared.
- R9: grant and stall are never both 1. With req_valid=0 both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An issue request is present this cycle |
| req_width | input | 2 | Width code of the request |
| wide_cfg | input | 1 | 0: 32 and 64 bytes count as wide; 1: 64 bytes only |
| grant | output | 1 | The request issues this cycle |
| stall | output | 1 | The request is held back this cycle |
| vec_state | output | 2 | Current datapath state |

## Verification
The bench builds the block with WARM_CYCLES=6 and IDLE_CYCLES=10. With these values, a full warm-up with its alternating grant and stall pattern fits in a handful of table rows. A complete idle revert, and a restart of the idle count partway through, also fit in a few dozen cycles. Both wide_cfg settings and the reserved width code are driven across the COLD-to-WARMING edge. A reset is applied in the middle of a warm-up.

// File: rtl/vw_pkg.sv
package vw_pkg;

    typedef enum logic [1:0] {
        VW_COLD    = 2'd0,
        VW_WARMING = 2'd1,
        VW_WARM    = 2'd2
    } vw_state_e;

    typedef enum logic [1:0] {
        VW_W16  = 2'd0,
        VW_W32  = 2'd1,
        VW_W64  = 2'd2,
        VW_WRSV = 2'd3
    } vw_width_e;

    typedef enum logic {
        VW_SEL_32UP   = 1'b0,
        VW_SEL_64ONLY = 1'b1
    } vw_sel_e;

    typedef struct packed {
        logic valid;
        logic wide;
    } vw_req_t;

    // Reserved code is treated conservatively as the widest class.
    function automatic logic vw_is_wide(vw_width_e w, vw_sel_e s);
        logic r;
        case (w)
            VW_W16:  r = 1'b0;
            VW_W32:  r = (s == VW_SEL_32UP);
            VW_W64:  r = 1'b1;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vw_classify.sv
module vw_classify
    import vw_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] width,
    input  logic       cfg,
    output vw_req_t    req
);
    always_comb begin
        req.valid = valid;
        req.wide  = valid && vw_is_wide(vw_width_e'(width), vw_sel_e'(cfg));
    end

    // R2: a 16-byte request is never classed wide
    always_comb begin
        if (valid && (width == 2'd0))
            a_r2_narrow_code: assert (!req.wide);
    end
endmodule

// File: rtl/vw_timer.sv
module vw_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic done
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (step)
            cnt <= done ? '0 : cnt + 1'b1;
    end

    // R5 / R7: the count never passes its terminal value
    a_r5_timer_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/vw_fsm.sv
module vw_fsm
    import vw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  vw_req_t   req,
    input  logic      warm_done,
    input  logic      idle_done,
    output logic      grant,
    output logic      stall,
    output vw_state_e state,
    output logic      warm_step,
    output logic      warm_clear,
    output logic      idle_step,
    output logic      idle_clear
);
    vw_state_e state_nx;
    logic      prev_wg;
    logic      throttled;
    logic      wide_gnt;

    assign throttled = (state != VW_WARM);

    always_comb begin
        grant    = req.valid && (!req.wide || !throttled || !prev_wg);
        stall    = req.valid && !grant;
        wide_gnt = req.wide && grant;
    end

    always_comb begin
        warm_step  = ((state == VW_COLD) && req.wide) || (state == VW_WARMING);
        warm_clear = !warm_step;
        idle_step  = (state == VW_WARM) && !req.wide;
        idle_clear = !idle_step;
    end

    always_comb begin
        state_nx = state;
        case (state)
            VW_COLD:    if (req.wide) state_nx = warm_done ? VW_WARM : VW_WARMING;
            VW_WARMING: if (warm_done) state_nx = VW_WARM;
            VW_WARM:    if (idle_step && idle_done) state_nx = VW_COLD;
            default:    state_nx = VW_COLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= VW_COLD;
            prev_wg <= 1'b0;
        end else begin
            state   <= state_nx;
            prev_wg <= wide_gnt;
        end
    end

    a_r1_narrow_pass: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !req.wide) |-> (grant && !stall));

    a_r3_cold_enter: assert property (@(posedge clk) disable iff (rst)
        (state == VW_COLD && req.wide) |=> (state != VW_COLD));

    a_r4_half_rate: assert property (@(posedge clk) disable iff (rst)
        (wide_gnt && state != VW_WARM) |=> !(wide_gnt && state != VW_WARM));

    a_r6_warm_full: assert property (@(posedge clk) disable iff (rst)
        (state == VW_WARM && req.valid) |-> grant);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(grant && stall) && (req.valid || (!grant && !stall)));

    a_r3_legal_state: assert property (@(posedge clk) disable iff (rst)
        state != 2'd3);
endmodule

// File: rtl/vwarm_throttle.sv
module vwarm_throttle
    import vw_pkg::*;
#(
    parameter int unsigned WARM_CYCLES = 56000,
    parameter int unsigned IDLE_CYCLES = 2700000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_width,
    input  logic       wide_cfg,
    output logic       grant,
    output logic       stall,
    output logic [1:0] vec_state
);
    vw_req_t   req;
    vw_state_e st;
    logic warm_step, warm_clear, warm_done;
    logic idle_step, idle_clear, idle_done;

    vw_classify u_cls (
        .valid (req_valid),
        .width (req_width),
        .cfg   (wide_cfg),
        .req   (req)
    );

    vw_timer #(.LIMIT(WARM_CYCLES)) u_warm (
        .clk   (clk),
        .rst   (rst),
        .clear (warm_clear),
        .step  (warm_step),
        .done  (warm_done)
    );

    vw_timer #(.LIMIT(IDLE_CYCLES)) u_idle (
        .clk   (clk),
        .rst   (rst),
        .clear (idle_clear),
        .step  (idle_step),
        .done  (idle_done)
    );

    vw_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .warm_done  (warm_done),
        .idle_done  (idle_done),
        .grant      (grant),
        .stall      (stall),
        .state      (st),
        .warm_step  (warm_step),
        .warm_clear (warm_clear),
        .idle_step  (idle_step),
        .idle_clear (idle_clear)
    );

    assign vec_state = st;
endmodule

// File: tb/vwarm_throttle_tb_top.sv
module vwarm_throttle_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WARM_N = 6;
    localparam int IDLE_N = 10;
    localparam int NV = 32;

    logic clk = 1'b0;
    logic rst;
    logic req_valid;
    logic [1:0] req_width;
    logic wide_cfg;
    logic grant, stall;
    logic [1:0] vec_state;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vwarm_throttle #(.WARM_CYCLES(WARM_N), .IDLE_CYCLES(IDLE_N)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_width(req_width),
        .wide_cfg(wide_cfg), .grant(grant), .stall(stall), .vec_state(vec_state)
    );

    // {valid, width[1:0], cfg, exp_grant, exp_stall, exp_state[1:0], tag[3:0]}
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd9}, // v0  idle, R9
        {1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd1}, // v1  16B, R1
        {1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 4'd2}, // v2  32B narrow under cfg=1, R2
        {1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 4'd3}, // v3  32B wide in COLD, R3
        {1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 2'd1, 4'd4}, // v4  stall, R4
        {1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd1, 4'd4}, // v5  grant, R4
        {1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd1, 4'd1}, // v6  narrow in WARMING, R1
        {1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd1, 4'd4}, // v7  grant, R4
        {1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 2'd1, 4'd5}, // v8  last warm cycle, R5
        {1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd2, 4'd5}, // v9  WARM, R5
        {1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd2, 4'd6}, // v10 back-to-back, R6
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7}, // v11 idle 1, R7
        {1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd2, 4'd7},
        {1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7}, // v18 idle 8
        {1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd2, 4'd7}, // v19 wide reloads, R7
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7}, // v20 idle 1
        {1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7},
        {1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd7}, // v29 idle 10
        {1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 2'd0, 4'd7}, // v30 COLD again, rsv code wide
        {1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 2'd1, 4'd2}  // v31 rsv code throttled, R2
    };

    function automatic string tag_name(logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string rq, logic eg, logic es, logic [1:0] est);
        checks++;
        if (grant !== eg || stall !== es || vec_state !== est) begin
            errors++;
            $display("FAIL %s: grant=%0b stall=%0b state=%0d expected grant=%0b stall=%0b state=%0d",
                     rq, grant, stall, vec_state, eg, es, est);
        end
    endtask

    task automatic drive(logic v, logic [1:0] w, logic c);
        @(negedge clk);
        req_valid = v;
        req_width = w;
        wide_cfg  = c;
        #1;
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_width = 2'd0;
        wide_cfg  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R8", 1'b0, 1'b0, 2'd0);   // reset state

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][11], VEC[i][10:9], VEC[i][8]);
            check(tag_name(VEC[i][3:0]), VEC[i][7], VEC[i][6], VEC[i][5:4]);
        end

        // R8: reset in the middle of warm-up
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b1;
        req_width = 2'd2;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        req_valid = 1'b0;
        #1;
        check("R8", 1'b0, 1'b0, 2'd0);
        drive(1'b1, 2'd2, 1'b1);
        check("R8", 1'b1, 1'b0, 2'd0);   // half-rate history cleared
        drive(1'b1, 2'd2, 1'b1);
        check("R4", 1'b0, 1'b1, 2'd1);
        drive(1'b1, 2'd1, 1'b1);
        check("R1", 1'b1, 1'b0, 2'd1);   // 32B narrow under cfg=1
        drive(1'b1, 2'd1, 1'b0);
        check("R2", 1'b1, 1'b0, 2'd1);   // 32B wide, prev not wide
        drive(1'b1, 2'd1, 1'b0);
        check("R2", 1'b0, 1'b1, 2'd1);   // 32B wide, must alternate
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule